// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Read Cache

This block is a read-only cache built on a single direct-mapped line array that can still hold two lines whose addresses land on the same index. A lookup first checks the line at the address's home index. If that misses, the block checks a second slot: the home index with its top bit inverted. A hit in that second slot returns data one cycle later than a home hit. The two slots are then exchanged, so the line just used sits at its home slot for the next access. If both slots miss, the block fetches the line from the next memory level. The returned line is written at the home slot, and the line displaced from there moves to the partner slot.

Each stored entry holds a valid bit, a tag, the data word and a placement flag. The flag records whether the entry sits at its home slot or at its partner slot. Two different addresses that share a tag can therefore never be mistaken for each other. The CPU side is a request/response port whose latency depends on where the line is found. The memory side is a request handshake followed by a single-beat response.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first read of any address is therefore served from memory.
- R2: A request accepted on a clock edge (`req_valid && req_ready`) that hits at its home index (the low `IDX_W` address bits) gives `rsp_valid` in the very next cycle with `rsp_path` = 0 (`2'd0`). `req_ready` stays high, so home hits can be accepted on consecutive edges.
- R3: On a home miss, the block probes the partner index, which is the home index with bit `IDX_W-1` inverted. A hit there gives the response two cycles after acceptance, with `rsp_path` = 1 (`2'd1`).
- R4: After a partner-slot hit, the two slots exchange contents. A repeated read of the same address then hits at home (path 0), and the line that used to be at home hits on its partner probe (path 1).
- R5: `req_ready` is low while a request is in its partner probe, its exchange or its memory access. During the exchange it is still low in the cycle that carries the path-1 response, and it is high again in the following cycle.
- R6: When both probes miss, `mem_req_valid` rises with `mem_req_addr` equal to the full request address. Both are held stable until `mem_req_ready` is seen high.
- R7: On the cycle after `mem_rsp_valid`, the response carries `mem_rsp_data` with `rsp_path` = 2 (`2'd2`), and the block becomes ready again. The new line occupies its home slot. The former home line moves to the partner slot, and the former partner line is evicted, so its next read goes to memory.
- R8: An entry matches only when both its tag and its placement agree with the probe. An address whose tag matches the entry in its partner slot, but whose entry sits at its own home there, still misses and goes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | TAG_W+IDX_W | Line address: tag in the upper bits, index in the lower bits |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | DATA_W | Read data |
| rsp_path | output | 2 | Where the line was found: 0 home, 1 partner, 2 memory |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_ready | input | 1 | Next level accepts the line request |
| mem_req_addr | output | TAG_W+IDX_W | Requested line address |
| mem_rsp_valid | input | 1 | Line data from the next level valid |
| mem_rsp_data | input | DATA_W | Line data from the next level |

## Verification
The assertions assume that the memory side returns exactly one `mem_rsp_valid` pulse per accepted line request, and only after that request has been accepted. They also assume that `req_addr` stays stable while `req_valid` waits for `req_ready`. The bench's memory model delays `mem_req_ready` for two cycles on every request, then returns one response pulse a few cycles later. The CPU driver holds each address until it sees the request accepted. Under these conditions the path-2 and hold properties only ever see legal handshakes.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALT   = 3'd1,
        ST_SWAP  = 3'd2,
        ST_MREQ  = 3'd3,
        ST_MWAIT = 3'd4
    } pac_state_e;

    localparam logic [1:0] PATH_HOME = 2'd0;
    localparam logic [1:0] PATH_PART = 2'd1;
    localparam logic [1:0] PATH_MEM  = 2'd2;

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int IDX_W = 4,
    parameter int ENT_W = 42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx [2],
    output logic [ENT_W-1:0] rd_ent [2],
    input  logic             wr_en  [2],
    input  logic [IDX_W-1:0] wr_idx [2],
    input  logic [ENT_W-1:0] wr_ent [2]
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] line_d [DEPTH];
    logic [ENT_W-1:0] line_q [DEPTH];

    always_comb begin
        line_d = line_q;
        for (int p = 0; p < 2; p++) begin
            if (wr_en[p]) begin
                line_d[wr_idx[p]] = wr_ent[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            line_q <= line_d;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_rd
        assign rd_ent[g] = line_q[rd_idx[g]];
    end

    // R4
    dual_wr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && wr_en[1]) |-> (wr_idx[0] != wr_idx[1]));

endmodule

// File: rtl/pac_tag_match.sv
module pac_tag_match #(
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int ENT_W  = 2 + TAG_W + DATA_W
) (
    input  logic [ENT_W-1:0]  ent,
    input  logic [TAG_W-1:0]  tag,
    input  logic              want_part,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    logic             ent_vld;
    logic             ent_part;
    logic [TAG_W-1:0] ent_tag;

    assign ent_vld  = ent[ENT_W-1];
    assign ent_part = ent[ENT_W-2];
    assign ent_tag  = ent[TAG_W+DATA_W-1:DATA_W];
    assign data     = ent[DATA_W-1:0];
    assign hit      = ent_vld && (ent_part == want_part) && (ent_tag == tag);

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
    import pac_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [TAG_W+IDX_W-1:0]  req_addr,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    output logic [1:0]              rsp_path,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [TAG_W+IDX_W-1:0]  mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [DATA_W-1:0]       mem_rsp_data
);
    localparam int ADDR_W = TAG_W + IDX_W;
    localparam int ENT_W  = 2 + TAG_W + DATA_W;
    localparam logic [IDX_W-1:0] FLIP_MASK = IDX_W'(1) << (IDX_W - 1);
    localparam logic [ENT_W-1:0] PART_MASK = {2'b01, {(ENT_W-2){1'b0}}};

    typedef struct packed {
        pac_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic                rv;
        logic [DATA_W-1:0]   rd;
        logic [1:0]          rp;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  home_idx;
    logic [IDX_W-1:0]  part_idx;

    logic [IDX_W-1:0]  rd_idx [2];
    logic [ENT_W-1:0]  rd_ent [2];
    logic              wr_en  [2];
    logic [IDX_W-1:0]  wr_idx [2];
    logic [ENT_W-1:0]  wr_ent [2];
    logic              slot_hit  [2];
    logic [DATA_W-1:0] slot_data [2];

    assign cur_addr  = (regs_q.st == ST_IDLE) ? req_addr : regs_q.addr;
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
    assign home_idx  = cur_addr[IDX_W-1:0];
    assign part_idx  = home_idx ^ FLIP_MASK;
    assign rd_idx[0] = home_idx;
    assign rd_idx[1] = part_idx;

    pac_line_store #(
        .IDX_W (IDX_W),
        .ENT_W (ENT_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_ent (rd_ent),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent)
    );

    // slot 0 probes the home index expecting a home-placed entry,
    // slot 1 probes the partner index expecting a partner-placed entry
    for (genvar g = 0; g < 2; g++) begin : g_probe
        pac_tag_match #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .ENT_W  (ENT_W)
        ) u_match (
            .ent       (rd_ent[g]),
            .tag       (cur_tag),
            .want_part (g == 1),
            .hit       (slot_hit[g]),
            .data      (slot_data[g])
        );
    end

    always_comb begin
        regs_d    = regs_q;
        regs_d.rv = 1'b0;
        wr_en[0]  = 1'b0;
        wr_en[1]  = 1'b0;
        wr_idx[0] = home_idx;
        wr_idx[1] = part_idx;
        wr_ent[0] = '0;
        wr_ent[1] = '0;
        case (regs_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.addr = req_addr;
                    if (slot_hit[0]) begin
                        regs_d.rv = 1'b1;
                        regs_d.rd = slot_data[0];
                        regs_d.rp = PATH_HOME;
                    end else begin
                        regs_d.st = ST_ALT;
                    end
                end
            end
            ST_ALT: begin
                if (slot_hit[1]) begin
                    regs_d.rv = 1'b1;
                    regs_d.rd = slot_data[1];
                    regs_d.rp = PATH_PART;
                    regs_d.st = ST_SWAP;
                end else begin
                    regs_d.st = ST_MREQ;
                end
            end
            ST_SWAP: begin
                wr_en[0]  = 1'b1;
                wr_en[1]  = 1'b1;
                wr_ent[0] = rd_ent[1] ^ PART_MASK;
                wr_ent[1] = rd_ent[0] ^ PART_MASK;
                regs_d.st = ST_IDLE;
            end
            ST_MREQ: begin
                if (mem_req_ready) begin
                    regs_d.st = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    wr_en[0]  = 1'b1;
                    wr_en[1]  = 1'b1;
                    wr_ent[0] = {1'b1, 1'b0, cur_tag, mem_rsp_data};
                    wr_ent[1] = rd_ent[0] ^ PART_MASK;
                    regs_d.rv = 1'b1;
                    regs_d.rd = mem_rsp_data;
                    regs_d.rp = PATH_MEM;
                    regs_d.st = ST_IDLE;
                end
            end
            default: begin
                regs_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready     = (regs_q.st == ST_IDLE);
    assign rsp_valid     = regs_q.rv;
    assign rsp_data      = regs_q.rd;
    assign rsp_path      = regs_q.rp;
    assign mem_req_valid = (regs_q.st == ST_MREQ);
    assign mem_req_addr  = regs_q.addr;

    // R2
    home_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_path == PATH_HOME) |-> $past(req_valid && req_ready));

    // R3
    part_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_path == PATH_PART) |-> $past(!req_ready));

    // R5
    swap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_path == PATH_PART) |-> !req_ready);

    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    fill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_path == PATH_MEM) |-> $past(mem_rsp_valid));

    // R1
    path_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_path != 2'd3));

endmodule

// File: tb/sim_pseudo_assoc_cache.sv
module sim_pseudo_assoc_cache;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = TAG_W + IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [1:0]        rsp_path;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    pseudo_assoc_cache #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_path(rsp_path),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [ADDR_W-1:0] last_addr = '0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [1:0]        path;
        int                acc;
        string             req;
    } exp_t;

    exp_t sb[$];

    function automatic logic [DATA_W-1:0] fdat(logic [ADDR_W-1:0] a);
        return {4'h5, a, 4'hC, a};
    endfunction

    task automatic chk(bit ok, string r, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // driver: push expectation, hold request until accepted
    task automatic issue(logic [ADDR_W-1:0] a, logic [1:0] path, string r);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        it.a = a; it.path = path; it.acc = cyc + 1; it.req = r;
        sb.push_back(it);
        last_addr = a;
        @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0 || !req_ready) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", rsp_data, 0);
            end else begin
                exp_t it;
                int lat;
                it = sb.pop_front();
                lat = cyc - it.acc + 1;
                chk(rsp_data == fdat(it.a), it.req, "data", rsp_data, fdat(it.a));
                chk(rsp_path == it.path, it.req, "path", rsp_path, it.path);
                if (it.path == 2'd0) chk(lat == 1, "R2", "home latency", lat, 1);
                if (it.path == 2'd1) begin
                    chk(lat == 2, "R3", "partner latency", lat, 2);
                    chk(!req_ready, "R5", "ready during swap", req_ready, 0);
                end
                if (it.path == 2'd2) chk(req_ready, "R7", "ready after fill", req_ready, 1);
            end
        end
    end

    // next-level memory model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [ADDR_W-1:0] ma;
                ma = mem_req_addr;
                chk(ma == last_addr, "R6", "request address", ma, last_addr);
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    chk(mem_req_valid && mem_req_addr == ma, "R6", "held request",
                        mem_req_addr, ma);
                    chk(!req_ready, "R5", "ready during miss", req_ready, 0);
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int k = 0; k < 2; k++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = fdat(ma);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R1", "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp after reset", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "mem req after reset", mem_req_valid, 0);

        // A home idx 2, C same index other tag, B same tag as A at idx 10
        issue(12'h112, 2'd2, "R1");  drain();
        issue(12'h112, 2'd0, "R2");  drain();
        issue(12'h222, 2'd2, "R7");  drain();   // A moves to idx 10
        issue(12'h112, 2'd1, "R3");  drain();   // partner hit, swap
        issue(12'h112, 2'd0, "R4");  drain();
        issue(12'h222, 2'd1, "R4");  drain();   // former home line on partner
        issue(12'h222, 2'd0, "R4");  drain();
        issue(12'h11A, 2'd2, "R8");  drain();   // tag match but wrong placement
        issue(12'h112, 2'd0, "R7");  drain();   // A moved back home
        issue(12'h11A, 2'd0, "R7");  drain();
        issue(12'h222, 2'd2, "R7");  drain();   // C was evicted
        issue(12'h11A, 2'd2, "R7");  drain();   // B evicted by C fill

        // top-half home index
        issue(12'h33D, 2'd2, "R6");  drain();
        issue(12'h44D, 2'd2, "R6");  drain();
        issue(12'h33D, 2'd1, "R3");  drain();
        issue(12'h33D, 2'd0, "R4");  drain();

        // back-to-back home hits
        issue(12'h035, 2'd2, "R7");  drain();
        issue(12'h046, 2'd2, "R7");  drain();
        t0 = cyc;
        issue(12'h035, 2'd0, "R2");
        issue(12'h046, 2'd0, "R2");
        issue(12'h035, 2'd0, "R2");
        chk(cyc == t0 + 3, "R2", "back-to-back acceptance", cyc - t0, 3);
        drain();
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2", "pending expectations", sb.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule